// File: doc/BRIEF.md
# Page-Buffered Self-Timed Programming Controller

This block is the write-side controller of a paged nonvolatile memory. A host drives an asynchronous-style interface (active-low select, write strobe and output enable, an address and a data byte in each direction). Bytes it writes land in a one-page staging buffer rather than in the array. Once the host has stopped writing for a set number of timebase ticks, the controller opens a programming interval of a fixed tick count. During that interval it copies the whole staging buffer into the storage array through a byte-wide write port, one byte per clock.

While the interval runs, the block ignores host writes. Any read returns the inverted value of the last byte loaded, so software can poll one location until the true data comes back. An inhibit input holds off the start of programming. A whole-array mode input copies the buffer into every page instead of only the addressed one. The storage array sits outside the block, behind a write port and a combinational read port.

Top module: `pgprog_ctrl`

## Requirements
- R1: The address is split into a byte offset in bits [OFFS_W-1:0] (7 bits by default) and a page number in the bits above it (10 bits by default). The array location of a byte is page*2^OFFS_W + offset.
- R2: A byte is loaded only while host_sel_n and host_wr_n are both low. The address is taken in the first clock where both are seen low. The data is taken in the first clock afterwards where either one is seen high.
- R3: The page of a sequence comes from the first byte loaded after idle. Later bytes in the same sequence use only their offset, and offsets may come in any order.
- R4: Each loaded byte restarts the quiet count. busy rises on the clock edge of the QUIET_TICKS-th tick after the last loaded byte, provided inhibit_n is high.
- R5: busy is low out of reset. Once high, it falls on the clock edge of the PROG_TICKS-th tick counted after it rose.
- R6: All 2^OFFS_W buffer bytes are written to the page, including bytes not loaded in the current sequence. The buffer keeps its contents across sequences and resets to 8'hFF.
- R7: While busy is high, host_dout carries the bitwise inverse of the last loaded byte, whatever the address.
- R8: While busy is low, host_dout carries the array data at host_addr.
- R9: host_dout_en is high only when host_sel_n and host_oe_n are low and host_wr_n is high. A deselected host sees it low even while busy is high.
- R10: While inhibit_n is low, busy cannot rise. If the quiet window has already elapsed, busy rises on the first clock edge at which inhibit_n is high.
- R11: If chip_cycle is high at the end of any byte load in a sequence, the buffer is written at its offset into every page.
- R12: Host write cycles that begin or end while busy is high change neither the buffer, nor the polled value, nor any counter.
- R13: Once busy rises, mem_we is high for exactly 2^OFFS_W consecutive clocks (or 2^(OFFS_W+PAGE_W) in whole-array mode), and only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse |
| inhibit_n | input | 1 | Low blocks the start of programming |
| chip_cycle | input | 1 | High during a byte load selects whole-array programming |
| host_sel_n | input | 1 | Active-low select |
| host_wr_n | input | 1 | Active-low write strobe |
| host_oe_n | input | 1 | Active-low output enable |
| host_addr | input | OFFS_W+PAGE_W | Page and byte address |
| host_din | input | 8 | Write data |
| host_dout | output | 8 | Read data (array data or inverted last byte) |
| host_dout_en | output | 1 | Tri-state enable for host_dout |
| busy | output | 1 | Programming interval in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | OFFS_W+PAGE_W | Array address (sweep while busy, host address otherwise) |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data for mem_addr |

## Verification
A load takes effect on the edge that sees the strobe pair return high. From that edge, busy rises on the edge carrying the QUIET_TICKS-th later tick, or on the first edge with inhibit_n high after that, and falls on the edge carrying the PROG_TICKS-th tick after that. The read path is combinational, so host_dout follows host_addr within the same cycle, and the inverted value appears in the same cycle busy rises. The reference model in the bench updates at each rising edge from the inputs held there, and it is compared with the outputs one nanosecond later. Inputs change only on falling edges. The directed readbacks are taken only after busy has fallen and the sweep is complete.

// File: rtl/pgprog_pkg.sv
package pgprog_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_LOAD = 2'd1,
    PG_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgprog_strobe.sv
// Host write-cycle qualification: address at cycle start, data at cycle end.
module pgprog_strobe #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr
);
  logic              act, act_q, armed_q, armed_d;
  logic              begin_ev, end_ev;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign act      = ~sel_n & ~wr_n;
  assign begin_ev = act & ~act_q & ~busy;
  assign end_ev   = ~act & act_q & armed_q & ~busy;

  always_comb begin
    armed_d = begin_ev | (armed_q & ~end_ev & ~busy);
    addr_d  = begin_ev ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      act_q   <= act;
      armed_q <= armed_d;
      addr_q  <= addr_d;
    end
  end

  assign ld_valid = end_ev;
  assign ld_addr  = addr_q;
endmodule

// File: rtl/pgprog_latch.sv
// One-page staging buffer, reset to all ones.
module pgprog_latch #(
  parameter int OFFS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFFS_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [OFFS_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << OFFS_W;

  logic [7:0] buf_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= 8'hFF;
    end else if (we) begin
      buf_q[waddr] <= wdata;
    end
  end

  assign rdata = buf_q[raddr];
endmodule

// File: rtl/pgprog_seq.sv
// Quiet window, programming interval and array write sweep.
module pgprog_seq
  import pgprog_pkg::*;
#(
  parameter int OFFS_W      = 7,
  parameter int PAGE_W      = 10,
  parameter int QUIET_TICKS = 500,
  parameter int PROG_TICKS  = 20000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     inhibit_n,
  input  logic                     chip_cycle,
  input  logic                     ld_valid,
  input  logic [PAGE_W-1:0]        ld_page,
  output logic                     busy,
  output logic                     wr_en,
  output logic [OFFS_W+PAGE_W-1:0] wr_addr,
  output logic [OFFS_W-1:0]        rd_off
);
  localparam int ADDR_W = OFFS_W + PAGE_W;
  localparam int QW     = $clog2(QUIET_TICKS + 1);
  localparam int PW     = $clog2(PROG_TICKS + 1);

  pg_state_e         state_q, state_d;
  logic [QW-1:0]     qcnt_q, qcnt_d;
  logic [PW-1:0]     pcnt_q, pcnt_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              chip_q, chip_d;
  logic [ADDR_W-1:0] sweep_q, sweep_d;
  logic              done_q, done_d;
  logic              q_full, go, p_full, p_end, sweep_last;

  assign q_full     = (qcnt_q == QW'(QUIET_TICKS));
  assign go         = inhibit_n & (q_full | (tick & (qcnt_q == QW'(QUIET_TICKS - 1))));
  assign p_full     = (pcnt_q == PW'(PROG_TICKS));
  assign p_end      = (pcnt_q >= PW'(PROG_TICKS - 1));
  assign sweep_last = chip_q ? (&sweep_q) : (&sweep_q[OFFS_W-1:0]);

  assign busy    = (state_q == PG_PROG);
  assign wr_en   = busy & ~done_q;
  assign wr_addr = chip_q ? sweep_q : {page_q, sweep_q[OFFS_W-1:0]};
  assign rd_off  = sweep_q[OFFS_W-1:0];

  always_comb begin
    state_d = state_q;
    qcnt_d  = qcnt_q;
    pcnt_d  = pcnt_q;
    page_d  = page_q;
    chip_d  = chip_q;
    sweep_d = sweep_q;
    done_d  = done_q;
    unique case (state_q)
      PG_IDLE: begin
        if (ld_valid) begin
          state_d = PG_LOAD;
          qcnt_d  = '0;
          page_d  = ld_page;
          chip_d  = chip_cycle;
        end
      end
      PG_LOAD: begin
        if (ld_valid) begin
          qcnt_d = '0;
          chip_d = chip_q | chip_cycle;
        end else begin
          if (tick && !q_full) qcnt_d = qcnt_q + 1'b1;
          if (go) begin
            state_d = PG_PROG;
            pcnt_d  = '0;
            sweep_d = '0;
            done_d  = 1'b0;
          end
        end
      end
      PG_PROG: begin
        if (wr_en) begin
          sweep_d = sweep_q + 1'b1;
          if (sweep_last) done_d = 1'b1;
        end
        if (tick && !p_full) pcnt_d = pcnt_q + 1'b1;
        if (tick && p_end && done_q) begin
          state_d = PG_IDLE;
          chip_d  = 1'b0;
        end
      end
      default: state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      qcnt_q  <= '0;
      pcnt_q  <= '0;
      page_q  <= '0;
      chip_q  <= 1'b0;
      sweep_q <= '0;
      done_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      qcnt_q  <= qcnt_d;
      pcnt_q  <= pcnt_d;
      page_q  <= page_d;
      chip_q  <= chip_d;
      sweep_q <= sweep_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/pgprog_ctrl.sv
// Top: host port, polling read mux, array port.
module pgprog_ctrl #(
  parameter int OFFS_W      = 7,
  parameter int PAGE_W      = 10,
  parameter int QUIET_TICKS = 500,
  parameter int PROG_TICKS  = 20000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     inhibit_n,
  input  logic                     chip_cycle,
  input  logic                     host_sel_n,
  input  logic                     host_wr_n,
  input  logic                     host_oe_n,
  input  logic [OFFS_W+PAGE_W-1:0] host_addr,
  input  logic [7:0]               host_din,
  output logic [7:0]               host_dout,
  output logic                     host_dout_en,
  output logic                     busy,
  output logic                     mem_we,
  output logic [OFFS_W+PAGE_W-1:0] mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata
);
  localparam int ADDR_W = OFFS_W + PAGE_W;

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic              ld_valid;
  logic [ADDR_W-1:0] ld_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [OFFS_W-1:0] rd_off;
  logic [7:0]        last_q, last_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  pgprog_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_n    (host_sel_n),
    .wr_n     (host_wr_n),
    .busy     (busy),
    .addr     (host_addr),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr)
  );

  pgprog_latch #(.OFFS_W(OFFS_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (ld_valid),
    .waddr (ld_addr[OFFS_W-1:0]),
    .wdata (host_din),
    .raddr (rd_off),
    .rdata (mem_wdata)
  );

  pgprog_seq #(
    .OFFS_W      (OFFS_W),
    .PAGE_W      (PAGE_W),
    .QUIET_TICKS (QUIET_TICKS),
    .PROG_TICKS  (PROG_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .inhibit_n  (inhibit_n),
    .chip_cycle (chip_cycle),
    .ld_valid   (ld_valid),
    .ld_page    (ld_addr[ADDR_W-1:OFFS_W]),
    .busy       (busy),
    .wr_en      (mem_we),
    .wr_addr    (wr_addr),
    .rd_off     (rd_off)
  );

  assign last_d = ld_valid ? host_din : last_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) last_q <= 8'hFF;
    else            last_q <= last_d;
  end

  assign mem_addr     = busy ? wr_addr : host_addr;
  assign host_dout    = busy ? ~last_q : mem_rdata;
  assign host_dout_en = ~host_sel_n & ~host_oe_n & host_wr_n;
endmodule

// File: rtl/pgprog_chk.sv
module pgprog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       inhibit_n,
  input logic       busy,
  input logic       mem_we,
  input logic       host_dout_en,
  input logic [7:0] host_dout
);
  // R10
  start_needs_inhibit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(inhibit_n));

  // R5
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));

  // R13
  we_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R13
  sweep_single_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |=> !mem_we);

  // R7
  poll_value_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && host_dout_en && $past(host_dout_en)) |-> $stable(host_dout));
endmodule

bind pgprog_ctrl pgprog_chk u_pgprog_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .inhibit_n    (inhibit_n),
  .busy         (busy),
  .mem_we       (mem_we),
  .host_dout_en (host_dout_en),
  .host_dout    (host_dout)
);

// File: tb/test_pgprog_ctrl.sv
`timescale 1ns/1ps
module test_pgprog_ctrl;
  localparam int OW = 7;
  localparam int PW = 3;
  localparam int AW = OW + PW;
  localparam int QT = 12;
  localparam int PT = 300;
  localparam int NB = 1 << OW;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic inhibit_n = 1'b1;
  logic chip_cycle = 1'b0;
  logic host_sel_n = 1'b1;
  logic host_wr_n = 1'b1;
  logic host_oe_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic host_dout_en, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] arr [NA];

  int errors = 0, checks = 0, cyc = 0, we_cnt = 0, tdiv = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pgprog_ctrl #(.OFFS_W(OW), .PAGE_W(PW), .QUIET_TICKS(QT), .PROG_TICKS(PT)) i_pgprog_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit_n(inhibit_n), .chip_cycle(chip_cycle),
    .host_sel_n(host_sel_n), .host_wr_n(host_wr_n), .host_oe_n(host_oe_n),
    .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
    .host_dout_en(host_dout_en), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  // storage array owned by the bench
  initial for (int i = 0; i < NA; i++) arr[i] = 8'h00;
  always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;
  assign mem_rdata = arr[mem_addr];

  // timebase: one tick every four clocks
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_state = 0, m_q = 0, m_p = 0, m_page = 0, m_last = 8'hFF, m_addr = 0;
  bit m_busy = 0, m_chip = 0, m_armed = 0, m_act = 0;
  int m_buf [NB];
  int m_mem [NA];
  initial begin
    for (int i = 0; i < NB; i++) m_buf[i] = 8'hFF;
    for (int i = 0; i < NA; i++) m_mem[i] = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (mem_we) we_cnt++;
    if (rst_n) begin
      bit act, st, fin, old_busy;
      old_busy = m_busy;
      act = !host_sel_n && !host_wr_n;
      st  = act && !m_act && !old_busy;
      fin = !act && m_act && m_armed && !old_busy;
      if (fin) begin
        m_buf[m_addr % NB] = host_din;
        m_last = host_din;
        if (m_state == 0) begin m_page = m_addr / NB; m_chip = chip_cycle; end
        else m_chip = m_chip | chip_cycle;
        m_state = 1; m_q = 0;
      end else if (m_state == 1) begin
        if (tick && m_q < QT) m_q++;
        if (m_q == QT && inhibit_n) begin
          m_state = 2; m_p = 0; m_busy = 1;
          for (int p = 0; p < (1 << PW); p++)
            if (m_chip || p == m_page)
              for (int o = 0; o < NB; o++) m_mem[p*NB + o] = m_buf[o];
        end
      end else if (m_state == 2) begin
        if (tick) m_p++;
        if (m_p == PT) begin m_state = 0; m_busy = 0; m_chip = 0; end
      end
      if (st) begin m_armed = 1; m_addr = host_addr; end
      else if (fin || old_busy) m_armed = 0;
      m_act = act;
      #1;
      chk(busy == m_busy, "R4/R5 busy timing", busy, m_busy);
      chk(host_dout_en == (!host_sel_n && !host_oe_n && host_wr_n), "R9 enable", host_dout_en,
          (!host_sel_n && !host_oe_n && host_wr_n));
      if (host_dout_en && m_busy)  chk(host_dout == (~m_last & 8'hFF), "R7 poll", host_dout, ~m_last & 8'hFF);
      if (host_dout_en && !m_busy) chk(host_dout == m_mem[host_addr], "R8 read", host_dout, m_mem[host_addr]);
    end
  end

  // watchdog
  always @(posedge clk) if (cyc > 100000 && !finished) begin
    finished = 1;
    errors++; checks++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [AW-1:0] ad(input int page, input int off);
    return AW'(page * NB + off);
  endfunction

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d, input bit cc, input bit wr_first);
    @(negedge clk); host_oe_n = 1; host_addr = a; host_din = d; chip_cycle = cc;
    if (wr_first) host_wr_n = 0; else host_sel_n = 0;
    @(negedge clk); if (wr_first) host_sel_n = 0; else host_wr_n = 0;
    @(negedge clk); host_addr = ~a;
    @(negedge clk); host_sel_n = 1; host_wr_n = 1;
    @(negedge clk); chip_cycle = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input int exp, input string tag);
    @(negedge clk); host_addr = a; host_wr_n = 1; host_sel_n = 0; host_oe_n = 0;
    @(posedge clk); #2;
    chk(host_dout_en && host_dout == exp[7:0], tag, host_dout, exp);
    @(negedge clk); host_sel_n = 1; host_oe_n = 1;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // reset state
    chk(!busy, "R5 reset busy", busy, 0);
    chk(!mem_we, "R13 reset we", mem_we, 0);
    chk(!host_dout_en, "R9 reset enable", host_dout_en, 0);

    // R1 R3 R6 R7 R12: out-of-order bytes, page from the first byte
    base = we_cnt;
    wr_byte(ad(2, 5), 8'hA5, 0, 0);
    wr_byte(ad(6, 3), 8'h3C, 0, 0);
    while (!busy) @(negedge clk);
    rd(ad(7, 100), 8'hC3, "R7 poll inverted last byte");
    wr_byte(ad(2, 0), 8'h11, 0, 0);           // R12 ignored while busy
    rd(ad(1, 1), 8'hC3, "R12 last byte unchanged");
    wait_idle();
    chk(we_cnt - base == NB, "R13 page write count", we_cnt - base, NB);
    rd(ad(2, 5), 8'hA5, "R1 R8 page 2 offset 5");
    rd(ad(2, 3), 8'h3C, "R3 page from first byte");
    rd(ad(6, 3), 8'h00, "R3 other page untouched");
    rd(ad(2, 0), 8'hFF, "R6 R12 unloaded byte from reset buffer");

    // R2 R4: write-first ordering with address moved mid-cycle, window restart
    wr_byte(ad(4, 9), 8'h5A, 0, 1);
    wait_ticks(8);
    wr_byte(ad(4, 10), 8'h66, 0, 0);
    wait_ticks(10);
    chk(!busy, "R4 window restarted", busy, 0);
    wait_idle();
    rd(ad(4, 9), 8'h5A, "R2 address taken at start");
    rd(ad(4, 10), 8'h66, "R2 second byte");
    rd(ad(4, 5), 8'hA5, "R6 buffer kept across sequences");

    // R10: inhibit holds off the start
    inhibit_n = 0;
    wr_byte(ad(1, 1), 8'h81, 0, 0);
    wait_ticks(30);
    chk(!busy, "R10 held by inhibit", busy, 0);
    @(negedge clk); inhibit_n = 1;
    @(negedge clk);
    chk(busy, "R10 start once released", busy, 1);
    wait_idle();
    rd(ad(1, 1), 8'h81, "R10 data programmed");

    // R11 R9: whole-array programming, deselected while busy
    base = we_cnt;
    wr_byte(ad(3, 7), 8'h77, 1, 0);
    while (!busy) @(negedge clk);
    host_sel_n = 1; host_oe_n = 0;
    @(negedge clk);
    chk(busy && !host_dout_en, "R9 deselected while busy", host_dout_en, 0);
    host_oe_n = 1;
    wait_idle();
    chk(we_cnt - base == NA, "R13 whole-array write count", we_cnt - base, NA);
    rd(ad(0, 7), 8'h77, "R11 page 0");
    rd(ad(5, 7), 8'h77, "R11 page 5");
    rd(ad(7, 5), 8'hA5, "R11 R6 buffer copied");
    rd(ad(0, 1), 8'h81, "R11 page 0 offset 1");
    @(negedge clk); host_sel_n = 0; host_oe_n = 1;
    @(negedge clk);
    chk(!host_dout_en, "R9 oe high", host_dout_en, 0);
    host_sel_n = 1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule